// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using the outcomes of the branches that came before it. It holds a file of history shift registers, each `HIST_W` bits wide. Some program-counter bits pick one of those registers. With `HSEL_W = 0` there is a single history register for every branch; otherwise each group of branch addresses keeps its own history.

The history value picked for a branch is joined with `TSEL_W` further program-counter bits. Together they address one 2-bit saturating counter, held in one of `2**TSEL_W` pattern tables. The top bit of that counter is the prediction.

The core asks for a prediction on the lookup port. The answer comes back in the same cycle, or one cycle later when `LOOKUP_REG = 1`. When a branch resolves, the core reports its address and outcome on the update port. The block then trains the addressed counter and shifts the outcome into the selected history register, all in one clock edge.

Top module: `bp_two_level`

## Requirements
- R1: After reset every history register holds zero. Every counter holds the weak state chosen by `RESET_TAKEN` (1 = weakly taken, value 2; 0 = weakly not taken, value 1). Every lookup then predicts `RESET_TAKEN`.
- R2: On a valid update, the selected history register shifts left by one bit. The outcome bit (1 = taken) enters at bit 0, and the oldest bit is dropped.
- R3: PC bits `[PC_LSB +: HSEL_W]` select one of `2**HSEL_W` history registers. With `HSEL_W = 0`, one register serves all branches.
- R4: PC bits `[PC_LSB+HSEL_W +: TSEL_W]` select the pattern table. The counter index is `{table bits, history}`, with the history in the low `HIST_W` bits.
- R5: A taken update adds one to the addressed counter, stopping at 3. A not-taken update subtracts one, stopping at 0.
- R6: The prediction is bit 1 of the addressed counter. Counter values 0 to 3 mean strongly not taken, weakly not taken, weakly taken and strongly taken.
- R7: An update addresses its counter with the history as it stood before that update's outcome is shifted in.
- R8: A valid update changes exactly one counter and one history register. While the update valid input is low, no state changes.
- R9: When a lookup and an update address the same counter in the same cycle, the lookup returns the value from before the update.
- R10: With `LOOKUP_REG = 0`, the prediction follows the lookup PC within the same cycle, with no clock edge needed.

Each update reads one counter, steps it through a single increment/decrement unit and writes it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_pc_i | input | PC_W | Address of the branch being looked up |
| lk_taken_o | output | 1 | Predicted direction (1 = taken) |
| up_valid_i | input | 1 | A resolved branch is reported this cycle |
| up_pc_i | input | PC_W | Address of the resolved branch |
| up_taken_i | input | 1 | Actual outcome (1 = taken) |

## Verification
Directed runs of all-taken and all-not-taken updates on one address push a counter against each limit. A single reversed outcome then shows whether the counter saturated or wrapped around. A not-taken run that returns the history to zero separates indexing by the pre-shift history from indexing by the post-shift history. A lookup and an update on the same branch in the same cycle separates old-value from new-value forwarding. Random updates over a small pool of addresses make history registers and pattern tables overlap and collide. Lookups on neighbouring addresses then expose any wrong choice of history register or table.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    CTR_SNT = 2'd0,
    CTR_WNT = 2'd1,
    CTR_WT  = 2'd2,
    CTR_ST  = 2'd3
  } ctr_e;
endpackage

// File: rtl/bp_ctr_step.sv
// Single shared saturating increment/decrement unit.
module bp_ctr_step
  import bp_pkg::*;
(
  input  ctr_e cur_i,
  input  logic taken_i,
  output ctr_e nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (taken_i) begin
      if (cur_i != CTR_ST) nxt_o = ctr_e'(cur_i + 2'd1);
    end else begin
      if (cur_i != CTR_SNT) nxt_o = ctr_e'(cur_i - 2'd1);
    end
  end
endmodule

// File: rtl/bp_hist_file.sv
module bp_hist_file #(
  parameter int unsigned HIST_W = 4,
  parameter int unsigned SEL_W  = 2,
  localparam int unsigned NUM   = 1 << SEL_W,
  localparam int unsigned SELW  = (SEL_W > 0) ? SEL_W : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SELW-1:0]   lk_sel_i,
  input  logic [SELW-1:0]   up_sel_i,
  input  logic              up_we_i,
  input  logic              up_taken_i,
  output logic [HIST_W-1:0] lk_hist_o,
  output logic [HIST_W-1:0] up_hist_o
);
  logic [HIST_W-1:0] hist_q [NUM];
  logic [HIST_W:0]   shifted;

  assign lk_hist_o = hist_q[lk_sel_i];
  assign up_hist_o = hist_q[up_sel_i];
  assign shifted   = {up_hist_o, up_taken_i};

  for (genvar g = 0; g < NUM; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              hist_q[g] <= '0;
      else if (up_we_i && up_sel_i == SELW'(g)) hist_q[g] <= shifted[HIST_W-1:0];
    end

    a_r8_hist_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(up_we_i && up_sel_i == SELW'(g)) |=> $stable(hist_q[g]));
  end

  a_r2_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_we_i |=> hist_q[$past(up_sel_i)][0] == $past(up_taken_i));

  if (HIST_W > 1) begin : g_shift_chk
    a_r2_shift_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
      up_we_i |=> hist_q[$past(up_sel_i)][HIST_W-1:1] == $past(up_hist_o[HIST_W-2:0]));
  end
endmodule

// File: rtl/bp_pht.sv
module bp_pht
  import bp_pkg::*;
#(
  parameter int unsigned IDX_W     = 5,
  parameter ctr_e        RESET_VAL = CTR_WNT,
  localparam int unsigned DEPTH    = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [IDX_W-1:0] up_idx_i,
  input  logic             up_we_i,
  input  ctr_e             up_wdata_i,
  output ctr_e             lk_ctr_o,
  output ctr_e             up_ctr_o
);
  ctr_e mem_q [DEPTH];

  assign lk_ctr_o = mem_q[lk_idx_i];
  assign up_ctr_o = mem_q[up_idx_i];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[g] <= RESET_VAL;
      else if (up_we_i && up_idx_i == IDX_W'(g)) mem_q[g] <= up_wdata_i;
    end

    a_r8_ctr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(up_we_i && up_idx_i == IDX_W'(g)) |=> $stable(mem_q[g]));
  end
endmodule

// File: rtl/bp_two_level.sv
module bp_two_level
  import bp_pkg::*;
#(
  parameter int unsigned PC_W        = 32,
  parameter int unsigned PC_LSB      = 2,
  parameter int unsigned HIST_W      = 4,
  parameter int unsigned HSEL_W      = 2,
  parameter int unsigned TSEL_W      = 1,
  parameter bit          RESET_TAKEN = 1'b0,
  parameter bit          LOOKUP_REG  = 1'b0,
  localparam int unsigned HSELW      = (HSEL_W > 0) ? HSEL_W : 1,
  localparam int unsigned IDX_W      = TSEL_W + HIST_W,
  localparam ctr_e        RESET_VAL  = RESET_TAKEN ? CTR_WT : CTR_WNT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            lk_taken_o,
  input  logic            up_valid_i,
  input  logic [PC_W-1:0] up_pc_i,
  input  logic            up_taken_i
);
  logic [HSELW-1:0]  lk_hsel, up_hsel;
  logic [HIST_W-1:0] lk_hist, up_hist;
  logic [IDX_W-1:0]  lk_idx, up_idx;
  ctr_e              lk_ctr, up_ctr, up_nxt;

  if (HSEL_W > 0) begin : g_hsel
    assign lk_hsel = lk_pc_i[PC_LSB +: HSEL_W];
    assign up_hsel = up_pc_i[PC_LSB +: HSEL_W];
  end else begin : g_hsel_glob
    assign lk_hsel = '0;
    assign up_hsel = '0;
  end

  if (TSEL_W > 0) begin : g_tsel
    assign lk_idx = {lk_pc_i[PC_LSB+HSEL_W +: TSEL_W], lk_hist};
    assign up_idx = {up_pc_i[PC_LSB+HSEL_W +: TSEL_W], up_hist};
  end else begin : g_tsel_shared
    assign lk_idx = lk_hist;
    assign up_idx = up_hist;
  end

  bp_hist_file #(.HIST_W(HIST_W), .SEL_W(HSEL_W)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_sel_i   (lk_hsel),
    .up_sel_i   (up_hsel),
    .up_we_i    (up_valid_i),
    .up_taken_i (up_taken_i),
    .lk_hist_o  (lk_hist),
    .up_hist_o  (up_hist)
  );

  bp_pht #(.IDX_W(IDX_W), .RESET_VAL(RESET_VAL)) u_pht (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_idx_i   (lk_idx),
    .up_idx_i   (up_idx),
    .up_we_i    (up_valid_i),
    .up_wdata_i (up_nxt),
    .lk_ctr_o   (lk_ctr),
    .up_ctr_o   (up_ctr)
  );

  bp_ctr_step u_step (
    .cur_i   (up_ctr),
    .taken_i (up_taken_i),
    .nxt_o   (up_nxt)
  );

  if (LOOKUP_REG) begin : g_lk_reg
    logic taken_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) taken_q <= RESET_TAKEN;
      else         taken_q <= lk_ctr[1];
    end
    assign lk_taken_o = taken_q;
  end else begin : g_lk_comb
    assign lk_taken_o = lk_ctr[1];
  end

  // R5: the counter never moves against the outcome and never by more than one step
  a_r5_direction: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_i |-> (up_taken_i ? (up_nxt >= up_ctr) : (up_nxt <= up_ctr)));

  a_r5_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_i |-> ((up_nxt == up_ctr) ? (up_ctr == (up_taken_i ? CTR_ST : CTR_SNT))
                                       : ($countones(2'(up_nxt - up_ctr) ^ (up_taken_i ? 2'd1 : 2'd3)) == 0)));
endmodule

// File: tb/bp_two_level_bench.sv
module bp_two_level_bench;
  localparam int PC_W   = 32;
  localparam int HIST_W = 4;
  localparam int HSEL_W = 2;
  localparam int TSEL_W = 1;
  localparam int NH     = 1 << HSEL_W;
  localparam int NC     = 1 << (TSEL_W + HIST_W);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] lk_pc = '0;
  logic            lk_taken;
  logic            up_valid = 1'b0;
  logic [PC_W-1:0] up_pc = '0;
  logic            up_taken = 1'b0;

  int tests = 0;
  int fails = 0;
  int hist_m [NH];
  int ctr_m  [NC];

  always #10 clk = ~clk;

  bp_two_level #(.PC_W(PC_W), .HIST_W(HIST_W), .HSEL_W(HSEL_W), .TSEL_W(TSEL_W))
  u_bp_two_level (
    .clk_i(clk), .rst_ni(rst_n), .lk_pc_i(lk_pc), .lk_taken_o(lk_taken),
    .up_valid_i(up_valid), .up_pc_i(up_pc), .up_taken_i(up_taken)
  );

  function automatic int hsel(input logic [PC_W-1:0] pc);
    return int'(pc[2 +: HSEL_W]);
  endfunction

  function automatic int cidx(input logic [PC_W-1:0] pc);
    return (int'(pc[2+HSEL_W +: TSEL_W]) << HIST_W) | hist_m[hsel(pc)];
  endfunction

  function automatic logic model_pred(input logic [PC_W-1:0] pc);
    return ctr_m[cidx(pc)] >= 2;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NH; i++) hist_m[i] = 0;
    for (int i = 0; i < NC; i++) ctr_m[i] = 1;
  endtask

  task automatic check(input string tag, input logic exp);
    tests++;
    if (lk_taken !== exp) begin
      fails++;
      $display("FAIL %s pc=%h actual=%b expected=%b", tag, lk_pc, lk_taken, exp);
    end
  endtask

  // one cycle: drive at negedge, check before edge (old state), then train model
  task automatic cyc(input string tag, input logic [PC_W-1:0] lpc, input logic v,
                     input logic [PC_W-1:0] upc, input logic t);
    lk_pc = lpc; up_valid = v; up_pc = upc; up_taken = t;
    #2;
    check(tag, model_pred(lpc));
    @(posedge clk);
    if (v) begin
      int ci, hs;
      ci = cidx(upc);
      hs = hsel(upc);
      if (t) begin if (ctr_m[ci] < 3) ctr_m[ci]++; end
      else   begin if (ctr_m[ci] > 0) ctr_m[ci]--; end
      hist_m[hs] = ((hist_m[hs] << 1) | int'(t)) & ((1 << HIST_W) - 1);
    end
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [PC_W-1:0] p, q;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: every table and history register answers weakly not taken
    for (int i = 0; i < 64; i++) begin
      lk_pc = PC_W'(i << 2);
      #1;
      check("R1", 1'b0);
    end

    // R9: same-cycle lookup and update of one entry returns the old value
    p = 32'h0000_0000;
    cyc("R9", p, 1'b1, p, 1'b1);
    // R7/R3/R4: another register with zero history and the same table sees the trained entry 0
    q = 32'h0000_0004;
    cyc("R7", q, 1'b0, p, 1'b0);
    check("R7", 1'b1);
    // R10: combinational follow of lookup PC without a clock edge
    lk_pc = 32'h0000_0010; #1; check("R10", 1'b0);
    lk_pc = 32'h0000_0004; #1; check("R10", 1'b1);

    // R2/R5: fill history of register 1 with taken, saturate counter at all-ones history
    p = 32'h0000_0004;
    for (int i = 0; i < 9; i++) cyc("R2", p, 1'b1, p, 1'b1);
    cyc("R5", p, 1'b1, p, 1'b0);              // step down from 3 to 2
    for (int i = 0; i < 4; i++) cyc("R2", p, 1'b1, p, 1'b1);
    check("R5", model_pred(p));                // all-ones history, counter at 2

    // R5: floor at zero on register 2
    p = 32'h0000_0008;
    for (int i = 0; i < 6; i++) cyc("R5", p, 1'b1, p, 1'b0);
    cyc("R5", p, 1'b1, p, 1'b1);
    cyc("R5", p, 1'b0, p, 1'b0);

    // R8: valid low leaves every entry unchanged
    for (int i = 0; i < 40; i++)
      cyc("R8", PC_W'(($urandom % 16) << 2), 1'b0, PC_W'(($urandom % 16) << 2), 1'($urandom));
    for (int i = 0; i < 16; i++) cyc("R8", PC_W'(i << 2), 1'b0, '0, 1'b0);

    // R3/R4/R6: random collisions over a small address pool
    for (int i = 0; i < 3000; i++) begin
      logic [PC_W-1:0] u, l;
      u = {$urandom} & 32'hFFFF_FFC0 | PC_W'(($urandom % 16) << 2);
      l = ($urandom % 4 == 0) ? u : ({$urandom} & 32'hFFFF_FFC0 | PC_W'(($urandom % 16) << 2));
      cyc("R6", l, ($urandom % 5) != 0, u, ($urandom % 3) != 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule